// File: doc/BRIEF.md
# Dual-Port Memory with Collision Busy Arbitration

This block is a 2048-word by 16-bit memory with two fully independent ports, called left and right. Each port has its own address, write data, read data, enable, read enable and two byte-lane write strobes, so either byte of a word can be written alone. Reads are registered and return data one cycle after the request. The read output is forced to zero whenever the matching valid flag is low.

A parameter selects one of two roles. In the master role, the block watches both ports. When both ports are enabled on the same address, it picks a winner and raises a busy flag toward the losing port. The loser's writes are blocked internally, but its read still completes. The winning port is chosen as follows:
- If one port already held the address in the previous cycle, that port wins.
- If neither port held it, the left port wins.
- Once a conflict has a winner, that winner keeps priority for as long as the conflict lasts.

In the slave role, the block does no arbitration of its own. The busy inputs decide which writes are blocked, and the busy outputs repeat those inputs. Wiring a slave's busy inputs to a master's busy outputs, with both devices sharing the same address and control lines, gives a wider word that is arbitrated as one.

Top module: `dpram_busy`

## Requirements
- R1: Every one of the 2^11 word addresses, including 0 and 2047, can be written from one port and read back unchanged from either port.
- R2: Write strobe bit 0 writes data bits 7:0 and strobe bit 1 writes bits 15:8. A lane whose strobe is low keeps its old contents. Strobes have no effect while the port's enable is low.
- R3: When enable and read enable are both high at a clock edge, the port's rdata shows the word at that address after that edge, and rvalid is 1. If the same edge also writes that word, rdata shows the value from before the write. Otherwise rvalid is 0 and rdata is 0.
- R4: In the master role, a busy output is high only while both ports are enabled on equal addresses. It follows the inputs in the same cycle. If neither port held the address in the previous cycle, the left port wins and the right busy goes high.
- R5: A port whose busy is high has all of its lane writes blocked, but its read is still returned.
- R6: In the master role, a port that was enabled on the address in the previous cycle, while the other port was not, wins the new conflict. A winner keeps priority while both ports stay on the same address.
- R7: In the master role, when both ports write the same address, only the winning port's enabled lanes change the word.
- R8: In the slave role, each busy input blocks the writes of its own port, and each busy output equals its busy input.
- R9: In the slave role with both busy inputs low, when both ports write the same address, each lane takes the left port's data if the left strobe for that lane is set, and the right port's data otherwise.
- R10: In the master role, the busy inputs have no effect on writes or on the busy outputs.
- R11: Both ports can access different addresses in the same cycle, with no busy flag raised and both writes taking effect.
- R12: While reset is applied and directly after it, both rvalid outputs are 0, both rdata outputs are 0 and both busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_en | input | 1 | Left port enable |
| lt_oe | input | 1 | Left port read enable |
| lt_byte_we | input | 2 | Left lane write strobes (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| lt_addr | input | 11 | Left word address |
| lt_wdata | input | 16 | Left write data |
| lt_rdata | output | 16 | Left read data, zero when not valid |
| lt_rvalid | output | 1 | Left read data valid |
| lt_busy_i | input | 1 | Left busy from a master (slave role only) |
| lt_busy_o | output | 1 | Left busy flag |
| rt_en | input | 1 | Right port enable |
| rt_oe | input | 1 | Right port read enable |
| rt_byte_we | input | 2 | Right lane write strobes (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| rt_addr | input | 11 | Right word address |
| rt_wdata | input | 16 | Right write data |
| rt_rdata | output | 16 | Right read data, zero when not valid |
| rt_rvalid | output | 1 | Right read data valid |
| rt_busy_i | input | 1 | Right busy from a master (slave role only) |
| rt_busy_o | output | 1 | Right busy flag |

## Verification
The assertions check the following on every cycle:
- A busy flag is only raised during a same-address clash, and never on both ports at once.
- A fresh clash goes to the left port.
- A winner stays the winner for as long as its clash lasts, and a port that held the address first keeps it.
- A busy port never drives a lane write enable.
- Read valid follows enable and read enable one cycle later, and rdata is zero whenever valid is low.

Some outcomes only show in the memory contents, so only the bench scenarios can show them:
- which data actually lands in the array;
- lane merging when both ports write one word;
- read-before-write values;
- a cascaded slave storing the same winner's data as its master.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LT   = 2'd1,
    WIN_RT   = 2'd2
  } win_e;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lt_en,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              rt_en,
  input  logic [ADDR_W-1:0] rt_addr,
  output logic              lt_busy,
  output logic              rt_busy
);
  logic              lt_en_q, rt_en_q;
  logic [ADDR_W-1:0] lt_addr_q, rt_addr_q;
  logic [ADDR_W-1:0] lt_addr_d, rt_addr_d;
  win_e              win_q, win_d;
  logic              clash, lt_hold, rt_hold;

  // Current clash and which port kept its address from last cycle
  always_comb begin
    clash   = lt_en && rt_en && (lt_addr == rt_addr);
    lt_hold = lt_en_q && lt_en && (lt_addr_q == lt_addr);
    rt_hold = rt_en_q && rt_en && (rt_addr_q == rt_addr);
  end

  // Winner selection: carried-over winner, then holder, then left
  always_comb begin
    win_d = WIN_NONE;
    if (clash) begin
      if (lt_hold && rt_hold && (win_q != WIN_NONE)) begin
        win_d = win_q;
      end else if (rt_hold && !lt_hold) begin
        win_d = WIN_RT;
      end else begin
        win_d = WIN_LT;
      end
    end
    lt_addr_d = lt_en ? lt_addr : lt_addr_q;
    rt_addr_d = rt_en ? rt_addr : rt_addr_q;
  end

  assign lt_busy = (win_d == WIN_RT);
  assign rt_busy = (win_d == WIN_LT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_en_q   <= 1'b0;
      rt_en_q   <= 1'b0;
      lt_addr_q <= '0;
      rt_addr_q <= '0;
      win_q     <= WIN_NONE;
    end else begin
      lt_en_q   <= lt_en;
      rt_en_q   <= rt_en;
      lt_addr_q <= lt_addr_d;
      rt_addr_q <= rt_addr_d;
      win_q     <= win_d;
    end
  end

  assert_busy_only_on_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_busy || rt_busy) |-> (lt_en && rt_en && (lt_addr == rt_addr)));

  assert_single_loser_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lt_busy && rt_busy));

  assert_fresh_clash_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_en && rt_en && (lt_addr == rt_addr) && !$past(lt_en) && !$past(rt_en)) |-> rt_busy);

  assert_keep_rt_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lt_busy |=> (!(lt_en && rt_en && (lt_addr == $past(lt_addr)) && (rt_addr == $past(rt_addr))) || lt_busy));

  assert_keep_lt_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rt_busy |=> (!(lt_en && rt_en && (lt_addr == $past(lt_addr)) && (rt_addr == $past(rt_addr))) || rt_busy));

  assert_holder_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_en && !lt_en) |=> (!(lt_en && rt_en && (rt_addr == $past(rt_addr)) && (lt_addr == rt_addr)) || lt_busy));
endmodule

// File: rtl/dpram_lane_bank.sv
module dpram_lane_bank #(
  parameter int ADDR_W = 11,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              lt_re,
  input  logic              lt_we,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic [WIDTH-1:0]  lt_d,
  output logic [WIDTH-1:0]  lt_q,
  input  logic              rt_re,
  input  logic              rt_we,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [WIDTH-1:0]  rt_d,
  output logic [WIDTH-1:0]  rt_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] store [DEPTH];

  // Right first so a same-address left write takes precedence
  always_ff @(posedge clk) begin
    if (rt_we) begin
      store[rt_addr] <= rt_d;
    end
    if (lt_we) begin
      store[lt_addr] <= lt_d;
    end
  end

  // Registered reads see contents from before this edge's writes
  always_ff @(posedge clk) begin
    if (lt_re) begin
      lt_q <= store[lt_addr];
    end
    if (rt_re) begin
      rt_q <= store[rt_addr];
    end
  end
endmodule

// File: rtl/dpram_rd_port.sv
module dpram_rd_port #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             oe,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);
  logic valid_q, valid_d;

  always_comb begin
    valid_d = en && oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign rvalid = valid_q;
  assign rdata  = valid_q ? q : '0;

  assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oe) |=> rvalid);

  assert_no_valid_without_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && oe) |=> !rvalid);

  assert_zero_when_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));
endmodule

// File: rtl/dpram_busy.sv
module dpram_busy
  import dpram_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int LANES     = 2,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lt_en,
  input  logic                      lt_oe,
  input  logic [LANES-1:0]          lt_byte_we,
  input  logic [ADDR_W-1:0]         lt_addr,
  input  logic [LANES*LANE_W-1:0]   lt_wdata,
  output logic [LANES*LANE_W-1:0]   lt_rdata,
  output logic                      lt_rvalid,
  input  logic                      lt_busy_i,
  output logic                      lt_busy_o,
  input  logic                      rt_en,
  input  logic                      rt_oe,
  input  logic [LANES-1:0]          rt_byte_we,
  input  logic [ADDR_W-1:0]         rt_addr,
  input  logic [LANES*LANE_W-1:0]   rt_wdata,
  output logic [LANES*LANE_W-1:0]   rt_rdata,
  output logic                      rt_rvalid,
  input  logic                      rt_busy_i,
  output logic                      rt_busy_o
);
  localparam int DATA_W = LANES * LANE_W;

  // Asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic lt_busy_eff, rt_busy_eff;

  generate
    if (IS_MASTER) begin : g_master
      logic unused_busy_in;
      assign unused_busy_in = lt_busy_i ^ rt_busy_i;
      dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_sync),
        .lt_en   (lt_en),
        .lt_addr (lt_addr),
        .rt_en   (rt_en),
        .rt_addr (rt_addr),
        .lt_busy (lt_busy_eff),
        .rt_busy (rt_busy_eff)
      );
    end else begin : g_slave
      assign lt_busy_eff = lt_busy_i;
      assign rt_busy_eff = rt_busy_i;
    end
  endgenerate

  assign lt_busy_o = lt_busy_eff;
  assign rt_busy_o = rt_busy_eff;

  // Lane write enables gated by enable and busy
  logic [LANES-1:0] lt_we, rt_we;
  always_comb begin
    lt_we = (lt_en && !lt_busy_eff) ? lt_byte_we : '0;
    rt_we = (rt_en && !rt_busy_eff) ? rt_byte_we : '0;
  end

  logic [DATA_W-1:0] lt_q, rt_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpram_lane_bank #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_bank (
        .clk     (clk),
        .lt_re   (lt_en),
        .lt_we   (lt_we[g]),
        .lt_addr (lt_addr),
        .lt_d    (lt_wdata[g*LANE_W +: LANE_W]),
        .lt_q    (lt_q[g*LANE_W +: LANE_W]),
        .rt_re   (rt_en),
        .rt_we   (rt_we[g]),
        .rt_addr (rt_addr),
        .rt_d    (rt_wdata[g*LANE_W +: LANE_W]),
        .rt_q    (rt_q[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  dpram_rd_port #(.WIDTH(DATA_W)) u_lt_rd (
    .clk    (clk),
    .rst_n  (rst_sync),
    .en     (lt_en),
    .oe     (lt_oe),
    .q      (lt_q),
    .rdata  (lt_rdata),
    .rvalid (lt_rvalid)
  );

  dpram_rd_port #(.WIDTH(DATA_W)) u_rt_rd (
    .clk    (clk),
    .rst_n  (rst_sync),
    .en     (rt_en),
    .oe     (rt_oe),
    .q      (rt_q),
    .rdata  (rt_rdata),
    .rvalid (rt_rvalid)
  );

  assert_lt_busy_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    lt_busy_o |-> (lt_we == '0));

  assert_rt_busy_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    rt_busy_o |-> (rt_we == '0));
endmodule

// File: tb/dpram_busy_bench.sv
`timescale 1ns/1ps
module dpram_busy_bench;
  localparam logic [15:0] SMASK = 16'h5A5A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        lt_en, lt_oe, rt_en, rt_oe;
  logic [1:0]  lt_be, rt_be;
  logic [10:0] lt_a, rt_a;
  logic [15:0] lt_wd, rt_wd;
  logic        m_lt_bi, m_rt_bi, tb_s_lt_bi, tb_s_rt_bi, cascade;
  logic [15:0] m_lt_rd, m_rt_rd, s_lt_rd, s_rt_rd;
  logic        m_lt_rv, m_rt_rv, s_lt_rv, s_rt_rv;
  logic        m_lt_bo, m_rt_bo, s_lt_bo, s_rt_bo;
  logic        s_lt_bi, s_rt_bi;

  assign s_lt_bi = cascade ? m_lt_bo : tb_s_lt_bi;
  assign s_rt_bi = cascade ? m_rt_bo : tb_s_rt_bi;

  dpram_busy #(.IS_MASTER(1'b1)) u_dpram_busy (
    .clk(clk), .rst_n(rst_n),
    .lt_en(lt_en), .lt_oe(lt_oe), .lt_byte_we(lt_be), .lt_addr(lt_a), .lt_wdata(lt_wd),
    .lt_rdata(m_lt_rd), .lt_rvalid(m_lt_rv), .lt_busy_i(m_lt_bi), .lt_busy_o(m_lt_bo),
    .rt_en(rt_en), .rt_oe(rt_oe), .rt_byte_we(rt_be), .rt_addr(rt_a), .rt_wdata(rt_wd),
    .rt_rdata(m_rt_rd), .rt_rvalid(m_rt_rv), .rt_busy_i(m_rt_bi), .rt_busy_o(m_rt_bo)
  );

  dpram_busy #(.IS_MASTER(1'b0)) u_dpram_busy_slave (
    .clk(clk), .rst_n(rst_n),
    .lt_en(lt_en), .lt_oe(lt_oe), .lt_byte_we(lt_be), .lt_addr(lt_a), .lt_wdata(lt_wd ^ SMASK),
    .lt_rdata(s_lt_rd), .lt_rvalid(s_lt_rv), .lt_busy_i(s_lt_bi), .lt_busy_o(s_lt_bo),
    .rt_en(rt_en), .rt_oe(rt_oe), .rt_byte_we(rt_be), .rt_addr(rt_a), .rt_wdata(rt_wd ^ SMASK),
    .rt_rdata(s_rt_rd), .rt_rvalid(s_rt_rv), .rt_busy_i(s_rt_bi), .rt_busy_o(s_rt_bo)
  );

  logic [15:0] ref_m [2048];
  logic [15:0] ref_s [2048];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_all();
    lt_en = 0; lt_oe = 0; lt_be = 0; lt_a = 0; lt_wd = 0;
    rt_en = 0; rt_oe = 0; rt_be = 0; rt_a = 0; rt_wd = 0;
  endtask

  task automatic drive(input bit left, input logic en, input logic oe, input logic [1:0] be,
                       input logic [10:0] a, input logic [15:0] d);
    if (left) begin
      lt_en = en; lt_oe = oe; lt_be = be; lt_a = a; lt_wd = d;
    end else begin
      rt_en = en; rt_oe = oe; rt_be = be; rt_a = a; rt_wd = d;
    end
  endtask

  task automatic ref_wr(input bit slave, input logic [10:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] w;
    w = slave ? ref_s[a] : ref_m[a];
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    if (slave) ref_s[a] = w; else ref_m[a] = w;
  endtask

  task automatic wr_one(input bit left, input logic [10:0] a, input logic [15:0] d, input logic [1:0] be);
    idle_all();
    drive(left, 1, 0, be, a, d);
    step();
    ref_wr(0, a, d, be);
    ref_wr(1, a, d ^ SMASK, be);
    idle_all();
  endtask

  task automatic rd_one(input string req, input bit left, input logic [10:0] a);
    idle_all();
    drive(left, 1, 1, 2'b00, a, 16'h0);
    step();
    chk(req, "master rdata", left ? m_lt_rd : m_rt_rd, ref_m[a]);
    chk(req, "slave rdata",  left ? s_lt_rd : s_rt_rd, ref_s[a]);
    chk(req, "rvalid", {15'b0, left ? m_lt_rv : m_rt_rv}, 16'h1);
    idle_all();
  endtask

  task automatic t_reset();
    rst_n = 0; cascade = 1; m_lt_bi = 0; m_rt_bi = 0; tb_s_lt_bi = 0; tb_s_rt_bi = 0;
    idle_all();
    repeat (3) step();
    chk("R12", "rvalid in reset", {14'b0, m_lt_rv, m_rt_rv}, 16'h0);
    rst_n = 1;
    repeat (3) step();
    chk("R12", "rdata after reset", m_lt_rd | m_rt_rd | s_lt_rd | s_rt_rd, 16'h0);
    chk("R12", "busy after reset", {12'b0, m_lt_bo, m_rt_bo, s_lt_bo, s_rt_bo}, 16'h0);
  endtask

  task automatic t_basic();
    wr_one(1, 11'd0, 16'h1234, 2'b11);
    wr_one(1, 11'd2047, 16'hBEEF, 2'b11);
    wr_one(0, 11'd1000, 16'hC0DE, 2'b11);
    rd_one("R1", 0, 11'd0);
    rd_one("R1", 0, 11'd2047);
    rd_one("R1", 1, 11'd1000);
  endtask

  task automatic t_lanes();
    wr_one(1, 11'd20, 16'hAAAA, 2'b11);
    wr_one(1, 11'd20, 16'h1177, 2'b01);
    rd_one("R2", 1, 11'd20);
    wr_one(0, 11'd20, 16'h99FF, 2'b10);
    rd_one("R2", 0, 11'd20);
    // strobes while disabled do nothing
    idle_all();
    drive(1, 0, 0, 2'b11, 11'd20, 16'h0000);
    step();
    rd_one("R2", 1, 11'd20);
  endtask

  task automatic t_read_timing();
    logic [15:0] old_m;
    idle_all();
    drive(1, 1, 0, 2'b00, 11'd20, 16'h0);
    step();
    chk("R3", "rvalid without oe", {15'b0, m_lt_rv}, 16'h0);
    chk("R3", "rdata without oe", m_lt_rd, 16'h0);
    old_m = ref_m[20];
    drive(1, 1, 1, 2'b11, 11'd20, 16'h4321);
    step();
    chk("R3", "read-before-write", m_lt_rd, old_m);
    ref_wr(0, 11'd20, 16'h4321, 2'b11);
    ref_wr(1, 11'd20, 16'h4321 ^ SMASK, 2'b11);
    rd_one("R3", 1, 11'd20);
  endtask

  task automatic t_independent();
    idle_all();
    drive(1, 1, 0, 2'b11, 11'd300, 16'h3000);
    drive(0, 1, 0, 2'b11, 11'd301, 16'h3011);
    #1;
    chk("R11", "busy different addr", {14'b0, m_lt_bo, m_rt_bo}, 16'h0);
    step();
    ref_wr(0, 11'd300, 16'h3000, 2'b11); ref_wr(1, 11'd300, 16'h3000 ^ SMASK, 2'b11);
    ref_wr(0, 11'd301, 16'h3011, 2'b11); ref_wr(1, 11'd301, 16'h3011 ^ SMASK, 2'b11);
    rd_one("R11", 0, 11'd300);
    rd_one("R11", 1, 11'd301);
  endtask

  task automatic t_fresh_clash();
    logic [15:0] old_m;
    wr_one(1, 11'd400, 16'h0400, 2'b11);
    old_m = ref_m[400];
    cascade = 1;
    idle_all();
    step();
    drive(1, 1, 0, 2'b11, 11'd400, 16'hAB01);
    drive(0, 1, 1, 2'b11, 11'd400, 16'hCD02);
    #1;
    chk("R4", "fresh clash busy {lt,rt}", {14'b0, m_lt_bo, m_rt_bo}, 16'h1);
    chk("R4", "slave busy follows master", {14'b0, s_lt_bo, s_rt_bo}, 16'h1);
    step();
    chk("R5", "busy port read returned", m_rt_rd, old_m);
    ref_wr(0, 11'd400, 16'hAB01, 2'b11); ref_wr(1, 11'd400, 16'hAB01 ^ SMASK, 2'b11);
    idle_all();
    #1;
    chk("R4", "busy drops when idle", {14'b0, m_lt_bo, m_rt_bo}, 16'h0);
    rd_one("R7", 1, 11'd400);
  endtask

  task automatic t_holder();
    logic [15:0] old_m;
    wr_one(0, 11'd500, 16'h0500, 2'b11);
    old_m = ref_m[500];
    idle_all();
    step();
    drive(0, 1, 1, 2'b00, 11'd500, 16'h0);
    step();
    drive(1, 1, 0, 2'b11, 11'd500, 16'h1111);
    drive(0, 1, 1, 2'b11, 11'd500, 16'h2222);
    #1;
    chk("R6", "holder right wins", {14'b0, m_lt_bo, m_rt_bo}, 16'h2);
    step();
    chk("R5", "winner read old value", m_rt_rd, old_m);
    ref_wr(0, 11'd500, 16'h2222, 2'b11); ref_wr(1, 11'd500, 16'h2222 ^ SMASK, 2'b11);
    drive(0, 1, 0, 2'b11, 11'd500, 16'h3333);
    #1;
    chk("R6", "winner kept", {14'b0, m_lt_bo, m_rt_bo}, 16'h2);
    step();
    ref_wr(0, 11'd500, 16'h3333, 2'b11); ref_wr(1, 11'd500, 16'h3333 ^ SMASK, 2'b11);
    drive(0, 0, 0, 2'b00, 11'd0, 16'h0);
    drive(1, 1, 0, 2'b01, 11'd500, 16'h4444);
    #1;
    chk("R6", "release clears busy", {14'b0, m_lt_bo, m_rt_bo}, 16'h0);
    step();
    ref_wr(0, 11'd500, 16'h4444, 2'b01); ref_wr(1, 11'd500, 16'h4444 ^ SMASK, 2'b01);
    rd_one("R7", 0, 11'd500);
  endtask

  task automatic t_slave();
    cascade = 0; tb_s_lt_bi = 1; tb_s_rt_bi = 0; m_lt_bi = 1; m_rt_bi = 1;
    idle_all();
    drive(1, 1, 0, 2'b11, 11'd600, 16'h6000);
    drive(0, 1, 0, 2'b11, 11'd601, 16'h6011);
    #1;
    chk("R8", "slave busy echo {lt,rt}", {14'b0, s_lt_bo, s_rt_bo}, 16'h2);
    chk("R10", "master ignores busy in", {14'b0, m_lt_bo, m_rt_bo}, 16'h0);
    step();
    ref_wr(0, 11'd600, 16'h6000, 2'b11);
    ref_wr(0, 11'd601, 16'h6011, 2'b11); ref_wr(1, 11'd601, 16'h6011 ^ SMASK, 2'b11);
    tb_s_lt_bi = 0; m_lt_bi = 0; m_rt_bi = 0;
    rd_one("R8", 1, 11'd600);
    rd_one("R10", 0, 11'd601);
    // both write one word, slave with no busy: lanes merge, left first
    wr_one(1, 11'd700, 16'h7070, 2'b11);
    idle_all();
    step();
    drive(1, 1, 0, 2'b01, 11'd700, 16'h11AA);
    drive(0, 1, 0, 2'b11, 11'd700, 16'h22BB);
    step();
    ref_m[700] = {ref_m[700][15:8], 8'hAA};
    ref_s[700] = {8'h22 ^ 8'h5A, 8'hAA ^ 8'h5A};
    idle_all();
    rd_one("R9", 0, 11'd700);
    cascade = 1;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_read_timing();
    t_independent();
    t_fresh_clash();
    t_holder();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule